// File: doc/BRIEF.md
# Privilege-Filtered Performance Counter Unit

This block holds six 32-bit event counters for a processor core. Four of them count an event chosen from a bus of one-cycle event pulses. One counts completed instructions and one counts clock cycles. Each counter can be frozen separately in each privilege state: hypervisor, supervisor, and two problem-state sub-modes. A global freeze bit stops all of them at once.

When an enabled counter reaches its sign bit, the block can latch an alert, drive a level interrupt, and optionally freeze every counter. Software reaches the control, event-select, freeze-mask and counter registers through a simple single-cycle register port. Register reads are combinational. Writes take effect on the next clock edge.

Top module: `perf_ctr_unit`

## Requirements
- R1: After a synchronous active-low reset, all counters read 0, the control register reads 0x80000000 (global freeze set, everything else clear), the select and freeze-mask registers read 0, and irq_o is 0.
- R2: Register addresses are 0 control, 1 event select, 2 freeze mask, and 3 to 8 counters 1 to 6. Counter n (n = 0..3, counters 1 to 4) takes its 8-bit code from select bits [(3-n)*8 +: 8], so counter 1 uses bits 31:24. Code k in 1..EVT_W counts pulses on event line k-1. Code 0, or a code above EVT_W, counts nothing.
- R3: Counter 5 counts only instr_done_i pulses, and counter 6 counts every clock cycle. Neither is affected by the select register or the event bus.
- R4: Freeze-mask bits below 10 read as 0. Counter n (n = 0..5) owns a 9-bit group at bit ((5-n)*9)+10. Within a group, bit 0x100 freezes the counter in supervisor state, 0x080 in problem state 0, 0x040 in problem state 1, and 0x004 in hypervisor state. The priv_i encoding is 0 hypervisor, 1 supervisor, 2 problem 0, 3 problem 1.
- R5: While control bit 31 (global freeze) is set, no counter changes except through a register write.
- R6: Control bits are: alert enable 26, alert flag 7, condition enable bit 15 for counter 1, and condition enable bit 14 for counters 2 to 6. If a counter has bit 31 set, its condition enable set and alert enable set at a clock edge, then the alert flag is set at that edge. irq_o is a registered copy of (alert flag AND alert enable), one cycle later.
- R7: If control bit 25 (freeze on condition) is set when the alert condition of R6 is met, global freeze is set at the same edge.
- R8: While control bit 12 and the alert flag are both set, every counter is frozen in the problem states (priv_i 2 or 3) and keeps counting in the other states.
- R9: Writing the alert flag to 0 clears it, unless the condition of R6 still holds in that cycle, in which case the flag (and, with bit 25, the global freeze) is set again at the same edge.
- R10: Counters are writable at any time, and a register write wins over an increment in the same cycle.
- R11: A counter that is not frozen keeps counting past 0x80000000 and wraps from 0xFFFFFFFF to 0.
- R12: Control bits that are not implemented read as 0, as do bits 63:32 of the control, select and counter registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | EVT_W | One-cycle event pulses, one per line |
| instr_done_i | input | 1 | Completed-instruction pulse |
| priv_i | input | 2 | Current privilege state |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data, combinational on the address |
| irq_o | output | 1 | Level alert interrupt |

## Verification
Each privilege state is exercised with a different number of event pulses on counters that are each frozen in a different state. A decoder that swaps two mask bits, or a group base that is off by one, therefore gives the wrong total on some counter.

The alert is approached one event at a time from 0x7FFFFFFE. The bench checks the exact cycle in which the flag, the global freeze from bit 25, and the one-cycle-later interrupt appear. A design that raises the alert a cycle early, or drives the interrupt without its register, misses one of these samples.

Clearing the flag while the counter is still overflowed must leave the alert set. A design that lets the write win loses an alert. A write landing during counting must replace the value, and the count must wrap past 0xFFFFFFFF. The problem-state freeze after an alert must stop counting only in problem states.

// File: rtl/pcu_pkg.sv
// Shared constants for the performance counter unit: privilege encoding,
// control-register bit positions, freeze-group bit positions, register map.
package pcu_pkg;

    typedef enum logic [1:0] {
        PRIV_HYP  = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_PRB0 = 2'd2,
        PRIV_PRB1 = 2'd3
    } priv_e;

    // control register bit positions
    localparam int CB_FRZ_ALL  = 31;
    localparam int CB_ALERT_EN = 26;
    localparam int CB_FOC      = 25;
    localparam int CB_CE_FIRST = 15;
    localparam int CB_CE_REST  = 14;
    localparam int CB_FRZ_PRB  = 12;
    localparam int CB_ALERT    = 7;

    // bit positions inside one counter's freeze group
    localparam int GB_SUP  = 8;
    localparam int GB_PRB0 = 7;
    localparam int GB_PRB1 = 6;
    localparam int GB_HYP  = 2;

    // register map
    localparam int A_CTRL = 0;
    localparam int A_SEL  = 1;
    localparam int A_FRZ  = 2;
    localparam int A_CTR0 = 3;

    // counter source variants
    localparam int SRC_SELECT = 0;
    localparam int SRC_INSTR  = 1;
    localparam int SRC_CYCLE  = 2;

endpackage

// File: rtl/pcu_evsel.sv
// Event selector: turns an 8-bit select code into a hit on one event line.
// Assumes code k (1..EVT_W) maps to line k-1; code 0 and codes above EVT_W
// never hit.
module pcu_evsel #(
    parameter int EVT_W = 8,
    parameter int SEL_W = 8
) (
    input  logic [SEL_W-1:0] sel_code_i,
    input  logic [EVT_W-1:0] evt_i,
    output logic             hit_o
);

    // compare the code against every line number
    always_comb begin
        hit_o = 1'b0;
        for (int k = 0; k < EVT_W; k++) begin
            if (sel_code_i == SEL_W'(k + 1)) begin
                hit_o = evt_i[k];
            end
        end
    end

endmodule

// File: rtl/pcu_counter.sv
// One event counter: a register write loads it, otherwise it steps by one
// when the count is allowed and its event hits. Wraps modulo 2^CTR_W.
module pcu_counter #(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CTR_W-1:0] wdata_i,
    input  logic             run_i,
    input  logic             hit_i,
    output logic [CTR_W-1:0] cnt_o
);

    // counter register, write has priority over increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (wr_en_i) begin
            cnt_o <= wdata_i;
        end else if (run_i && hit_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> cnt_o == $past(wdata_i)); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !(run_i && hit_i)) |=> $stable(cnt_o)); // R5
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && run_i && hit_i) |=> cnt_o == CTR_W'($past(cnt_o) + 1'b1)); // R11

endmodule

// File: rtl/pcu_ctrl.sv
// Control path: global control, select and freeze-mask registers, the
// per-counter run decision from privilege state, alert latching and the
// registered interrupt. Assumes NUM_CTR groups fit above FRZ_LSB in REG_W.
module pcu_ctrl
    import pcu_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int REG_W   = 64,
    parameter int GRP_W   = 9,
    parameter int FRZ_LSB = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctrl_i,
    input  logic               wr_sel_i,
    input  logic               wr_frz_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [1:0]         priv_i,
    input  logic [NUM_CTR-1:0] ovf_i,
    output logic [NUM_CTR-1:0] run_o,
    output logic [31:0]        ctrl_rd_o,
    output logic [31:0]        sel_o,
    output logic [REG_W-1:0]   frz_rd_o,
    output logic               irq_o
);

    logic                    frz_all_q, alert_en_q, foc_q, ce_first_q;
    logic                    ce_rest_q, frz_prb_q, flag_q;
    logic [REG_W-1:FRZ_LSB]  frz_q;
    logic [NUM_CTR-1:0]      ce_vec;
    logic                    cond_hit, in_prb;

    // condition enables per counter and the combined alert condition
    assign ce_vec   = {{(NUM_CTR-1){ce_rest_q}}, ce_first_q};
    assign cond_hit = alert_en_q && |(ovf_i & ce_vec);
    assign in_prb   = (priv_i == PRIV_PRB0) || (priv_i == PRIV_PRB1);

    // control register: software write, then alert set overrides
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_all_q  <= 1'b1;
            alert_en_q <= 1'b0;
            foc_q      <= 1'b0;
            ce_first_q <= 1'b0;
            ce_rest_q  <= 1'b0;
            frz_prb_q  <= 1'b0;
            flag_q     <= 1'b0;
        end else begin
            if (wr_ctrl_i) begin
                frz_all_q  <= wdata_i[CB_FRZ_ALL];
                alert_en_q <= wdata_i[CB_ALERT_EN];
                foc_q      <= wdata_i[CB_FOC];
                ce_first_q <= wdata_i[CB_CE_FIRST];
                ce_rest_q  <= wdata_i[CB_CE_REST];
                frz_prb_q  <= wdata_i[CB_FRZ_PRB];
                flag_q     <= wdata_i[CB_ALERT];
            end
            if (cond_hit) begin
                flag_q <= 1'b1;
                if (foc_q) begin
                    frz_all_q <= 1'b1;
                end
            end
        end
    end

    // event-select and freeze-mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o <= '0;
            frz_q <= '0;
        end else begin
            if (wr_sel_i) sel_o <= wdata_i[31:0];
            if (wr_frz_i) frz_q <= wdata_i[REG_W-1:FRZ_LSB];
        end
    end

    // registered level interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= flag_q & alert_en_q;
    end

    // per-counter run decision from its freeze group and the privilege state
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_run
        localparam int LSB = (NUM_CTR - 1 - n) * GRP_W + FRZ_LSB;
        logic [GRP_W-1:0] grp;
        logic             masked;
        assign grp = frz_q[LSB +: GRP_W];
        always_comb begin
            unique case (priv_i)
                PRIV_HYP:  masked = grp[GB_HYP];
                PRIV_SUP:  masked = grp[GB_SUP];
                PRIV_PRB0: masked = grp[GB_PRB0];
                default:   masked = grp[GB_PRB1];
            endcase
        end
        assign run_o[n] = !frz_all_q && !masked && !(frz_prb_q && flag_q && in_prb);
    end

    // read-back images
    always_comb begin
        ctrl_rd_o              = '0;
        ctrl_rd_o[CB_FRZ_ALL]  = frz_all_q;
        ctrl_rd_o[CB_ALERT_EN] = alert_en_q;
        ctrl_rd_o[CB_FOC]      = foc_q;
        ctrl_rd_o[CB_CE_FIRST] = ce_first_q;
        ctrl_rd_o[CB_CE_REST]  = ce_rest_q;
        ctrl_rd_o[CB_FRZ_PRB]  = frz_prb_q;
        ctrl_rd_o[CB_ALERT]    = flag_q;
        frz_rd_o               = {frz_q, {FRZ_LSB{1'b0}}};
    end

    AST_ALERT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_en_q && |(ovf_i & ce_vec)) |=> flag_q); // R6
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(alert_en_q)); // R6
    AST_FOC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_hit && foc_q) |=> frz_all_q); // R7
    AST_GLOBAL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        frz_all_q |-> run_o == '0); // R5
    AST_PRB_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && frz_prb_q && in_prb) |-> run_o == '0); // R8

endmodule

// File: rtl/perf_ctr_unit.sv
// Top of the performance counter unit: register decode and read mux, the
// control path, and one counter per slot. Slots below NUM_SEL take a
// selectable event, the next slot counts instructions, the last counts cycles.
module perf_ctr_unit
    import pcu_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int NUM_SEL = 4,
    parameter int CTR_W   = 32,
    parameter int EVT_W   = 8,
    parameter int SEL_W   = 8,
    parameter int REG_W   = 64,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              instr_done_i,
    input  logic [1:0]        priv_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);

    localparam int GRP_W   = 9;
    localparam int FRZ_LSB = 10;

    logic [NUM_CTR-1:0] run, ovf, ctr_we;
    logic [CTR_W-1:0]   cnt [NUM_CTR];
    logic [31:0]        ctrl_rd, sel;
    logic [REG_W-1:0]   frz_rd;

    pcu_ctrl #(
        .NUM_CTR (NUM_CTR),
        .REG_W   (REG_W),
        .GRP_W   (GRP_W),
        .FRZ_LSB (FRZ_LSB)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (reg_we_i && reg_addr_i == ADDR_W'(A_CTRL)),
        .wr_sel_i  (reg_we_i && reg_addr_i == ADDR_W'(A_SEL)),
        .wr_frz_i  (reg_we_i && reg_addr_i == ADDR_W'(A_FRZ)),
        .wdata_i   (reg_wdata_i),
        .priv_i    (priv_i),
        .ovf_i     (ovf),
        .run_o     (run),
        .ctrl_rd_o (ctrl_rd),
        .sel_o     (sel),
        .frz_rd_o  (frz_rd),
        .irq_o     (irq_o)
    );

    // counter slots, event source picked by slot position
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        logic hit;
        if (n < NUM_SEL) begin : g_sel
            pcu_evsel #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_evsel (
                .sel_code_i (sel[(NUM_SEL - 1 - n) * SEL_W +: SEL_W]),
                .evt_i      (evt_i),
                .hit_o      (hit)
            );
        end else if (n < NUM_CTR - 1) begin : g_instr
            assign hit = instr_done_i;
        end else begin : g_cycle
            assign hit = 1'b1;
        end

        assign ctr_we[n] = reg_we_i && reg_addr_i == ADDR_W'(A_CTR0 + n);
        assign ovf[n]    = cnt[n][CTR_W-1];

        pcu_counter #(.CTR_W(CTR_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en_i (ctr_we[n]),
            .wdata_i (reg_wdata_i[CTR_W-1:0]),
            .run_i   (run[n]),
            .hit_i   (hit),
            .cnt_o   (cnt[n])
        );
    end

    // combinational register read mux
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(A_CTRL)) reg_rdata_o = REG_W'(ctrl_rd);
        if (reg_addr_i == ADDR_W'(A_SEL))  reg_rdata_o = REG_W'(sel);
        if (reg_addr_i == ADDR_W'(A_FRZ))  reg_rdata_o = frz_rd;
        for (int n = 0; n < NUM_CTR; n++) begin
            if (reg_addr_i == ADDR_W'(A_CTR0 + n)) reg_rdata_o = REG_W'(cnt[n]);
        end
    end

endmodule

// File: tb/perf_ctr_unit_tb.sv
// Scoreboard bench: driver tasks queue expected values, a negedge monitor
// pops and compares them against the register port or the interrupt.
module perf_ctr_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt = '0;
    logic        instr = 1'b0;
    logic [1:0]  priv = 2'd1;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    logic rd_pend = 1'b0;
    logic done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [63:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    perf_ctr_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt),
        .instr_done_i (instr),
        .priv_i       (priv),
        .reg_we_i     (we),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq_o        (irq)
    );

    // monitor: pop one expected item per pending read and compare
    always @(negedge clk) begin
        if (rd_pend && sb_q.size() > 0) begin
            exp_t it;
            logic [63:0] got;
            it = sb_q.pop_front();
            got = it.is_irq ? {63'd0, irq} : rdata;
            n_run++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s got=%h exp=%h", it.tag, got, it.exp);
            end
        end
    end

    function automatic logic [63:0] grp(int n, logic [63:0] bits);
        return bits << ((5 - n) * 9 + 10);
    endfunction

    task automatic wr(input int a, input logic [63:0] d);
        we = 1'b1; addr = 4'(a); wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input int a, input logic [63:0] e, input string tag);
        exp_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        addr = 4'(a);
        sb_q.push_back(it);
        rd_pend = 1'b1;
        @(negedge clk);
        #1 rd_pend = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        exp_t it;
        it.is_irq = 1'b1; it.exp = {63'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        rd_pend = 1'b1;
        @(negedge clk);
        #1 rd_pend = 1'b0;
        @(posedge clk); #1;
    endtask

    localparam logic [63:0] ALLP = 64'h1C4;
    localparam logic [63:0] FRZ_ALL = 64'h8000_0000;

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // driver
    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk(0, 64'h8000_0000, "R1 ctrl reset");
        chk(1, 0, "R1 select reset");
        chk(2, 0, "R1 freeze reset");
        chk(3, 0, "R1 counter1 reset");
        chk(8, 0, "R1 counter6 reset");
        chk_irq(1'b0, "R1 irq reset");

        // R2 select mapping: c1 line0, c2 line1, c3 code 0, c4 line2
        priv = 2'd1;
        wr(1, 64'h0102_0003);
        wr(2, grp(5, ALLP));
        wr(0, 0);
        evt = 8'h07; idle(3);
        evt = 8'h01; idle(2);
        evt = 8'h00;
        wr(0, FRZ_ALL);
        chk(3, 5, "R2 counter1 line0");
        chk(4, 3, "R2 counter2 line1");
        chk(5, 0, "R2 counter3 code0");
        chk(6, 3, "R2 counter4 line2");

        // R3 fixed counters
        wr(1, 0);
        wr(2, 0);
        instr = 1'b1; evt = 8'hFF;
        wr(0, 0);
        idle(4);
        instr = 1'b0; evt = 8'h00;
        wr(0, FRZ_ALL);
        chk(7, 4, "R3 counter5 instr");
        chk(8, 5, "R3 counter6 cycles");
        chk(3, 5, "R3 counter1 ignores bus with code0");

        // R4 per-privilege freeze groups
        wr(3, 0); wr(4, 0); wr(5, 0); wr(6, 0);
        wr(1, 64'h0101_0101);
        wr(2, grp(0, 64'h100) | grp(1, 64'h004) | grp(2, 64'h080) |
              grp(3, 64'h040) | grp(4, ALLP) | grp(5, ALLP));
        priv = 2'd0;
        wr(0, 0);
        evt = 8'h01;
        priv = 2'd0; idle(1);
        priv = 2'd1; idle(2);
        priv = 2'd2; idle(3);
        priv = 2'd3; idle(4);
        evt = 8'h00;
        wr(0, FRZ_ALL);
        chk(3, 8, "R4 counter1 frozen supervisor");
        chk(4, 9, "R4 counter2 frozen hypervisor");
        chk(5, 7, "R4 counter3 frozen problem0");
        chk(6, 6, "R4 counter4 frozen problem1");
        chk(7, 4, "R4 counter5 masked");
        wr(2, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(2, 64'hFFFF_FFFF_FFFF_FC00, "R4 freeze low bits read zero");

        // R5 global freeze
        wr(2, 0);
        priv = 2'd0;
        evt = 8'h01; instr = 1'b1;
        idle(3);
        evt = 8'h00; instr = 1'b0;
        chk(3, 8, "R5 counter1 held by global freeze");
        chk(8, 5, "R5 counter6 held by global freeze");

        // R10 write beats increment
        evt = 8'h01;
        wr(0, 0);
        wr(3, 64'h100);
        idle(2);
        evt = 8'h00;
        wr(0, FRZ_ALL);
        chk(3, 64'h102, "R10 write during counting");

        // R11 wrap
        wr(3, 64'hFFFF_FFFE);
        evt = 8'h01;
        wr(0, 0);
        idle(3);
        evt = 8'h00;
        wr(0, FRZ_ALL);
        chk(3, 1, "R11 wrap to zero");

        // R6 R7 alert with freeze on condition, counter2
        priv = 2'd1;
        wr(4, 64'h7FFF_FFFE);
        evt = 8'h01;
        wr(0, 64'h0600_4000);
        chk_irq(1'b0, "R6 irq before overflow");
        chk_irq(1'b0, "R6 irq at 0x7fffffff");
        chk(0, 64'h0600_4000, "R6 flag not yet set");
        chk(0, 64'h8600_4080, "R7 flag and global freeze set");
        chk_irq(1'b1, "R6 irq one cycle later");
        chk(4, 64'h8000_0001, "R7 counter2 frozen after alert");
        evt = 8'h00;

        // R9 clear while still overflowed, then after rewrite
        wr(0, 64'h0600_4000);
        chk(0, 64'h8600_4080, "R9 alert refires while overflowed");
        wr(4, 0);
        wr(0, 64'h0600_4000);
        chk(0, 64'h0600_4000, "R9 alert cleared");
        chk_irq(1'b0, "R9 irq dropped");
        wr(0, FRZ_ALL);

        // R8 problem-state freeze after alert
        wr(3, 64'h8000_0000);
        wr(1, 64'h0100_0000);
        priv = 2'd2;
        wr(0, 64'h0400_9000);
        idle(2);
        evt = 8'h01;
        priv = 2'd2; idle(3);
        priv = 2'd3; idle(2);
        priv = 2'd1; idle(2);
        evt = 8'h00;
        wr(0, 64'h8400_9080);
        chk(3, 64'h8000_0002, "R8 counts only outside problem state");
        chk(0, 64'h8400_9080, "R8 ctrl image");
        chk_irq(1'b1, "R8 irq held");

        // R12 unimplemented control bits
        wr(0, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(0, 64'h8600_D080, "R12 ctrl implemented bits only");
        wr(1, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(1, 64'h0000_0000_FFFF_FFFF, "R12 select upper bits zero");

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule